// File: doc/BRIEF.md
# Paired-Register Serial Slave Engine

This block is the serial-bus slave front end for a small register file of eight byte-wide registers. The registers form four pairs: two read-only input ports (0 and 1), two output ports (2 and 3), two polarity registers (4 and 5) and two direction registers (6 and 7). The block oversamples the clock and data lines of a two-wire serial bus with its own system clock. It recognises START and STOP conditions, matches a 7-bit device address, and captures a command byte that sets an internal register pointer. It then moves data between the bus and a simple register-file port.

The pointer never walks through the map. After each data byte only its lowest bit flips, so a burst of any length alternates between the two registers of one pair. A master reads by writing the command, issuing a repeated START and re-addressing with the direction bit set. The block then shifts out register contents, MSB first, until the master declines to acknowledge a byte. The data line is open-drain: the block only ever pulls it low through an output enable.

Top module: `i2c_pair_ctrl`

## Requirements
- R1: After reset the block does not drive the data line (sda_oe = 0) and raises no register write (rf_we = 0).
- R2: The device address is 4'b0100 followed by addr_sel[2:0], and the eighth address bit is the direction bit (0 = write, 1 = read). On a match the block pulls the data line low during the ninth clock. On a mismatch it does not acknowledge, and it acknowledges nothing more until the next START.
- R3: The first byte after a write address is the command byte. It is always acknowledged. Its bits [2:0] load the register pointer and bits [7:3] are ignored.
- R4: Each acknowledged write data byte goes to the register under the pointer, and the pointer's bit 0 then flips. A burst of three bytes to register c therefore updates c, then c^1, then c again.
- R5: A write is committed as a one-cycle rf_we pulse, with rf_waddr and rf_wdata, only after the falling clock edge that ends the acknowledge bit. While the clock is high during that acknowledge, the register still holds its old value.
- R6: Data bytes written while the pointer is 0 or 1 are acknowledged, but they raise no rf_we, so the input registers keep their values.
- R7: After a repeated START and a read address, the block sends the register under the pointer, MSB first, and changes the data line only while the clock is low. After each byte the master acknowledges, bit 0 of the pointer flips and the next byte comes from the other register of the pair.
- R8: A byte the master does not acknowledge ends the read. The block releases the data line and drives nothing on further clocks until a START.
- R9: A STOP returns the block to idle, so bytes clocked after it are not acknowledged. A START seen in the middle of a byte restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the pad |
| sda_in | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | When 1 the pad pulls the data line low |
| addr_sel | input | 3 | Strap pins forming the low address bits |
| rf_we | output | 1 | One-cycle register write strobe |
| rf_waddr | output | 3 | Register index for the write |
| rf_wdata | output | 8 | Data byte for the write |
| rf_raddr | output | 3 | Register index the engine is reading (the pointer) |
| rf_rdata | input | 8 | Register contents for rf_raddr, combinational |

## Verification
A pointer that flips at the wrong moment or loads the wrong bits shows up on the next burst. Its second or third byte lands in, or reads back from, the wrong register of the pair, within one byte time on the bus. A byte-state machine that has lost its place shows up at the next ninth clock as a missing or extra acknowledge. A STOP or NACK that is not honoured shows up as the data line being pulled low where the master expects it released. Commit timing is checked against the acknowledge clock, so a write strobe that comes early is seen within that same bit.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BITCNT_W = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RLOAD,
    ST_RDATA,
    ST_RACK
  } eng_state_t;
endpackage

// File: rtl/i2cp_line_sync.sv
module i2cp_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_pipe[i] <= 1'b1;
            sda_pipe[i] <= 1'b1;
          end else begin
            scl_pipe[i] <= scl_in;
            sda_pipe[i] <= sda_in;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_pipe[i] <= 1'b1;
            sda_pipe[i] <= 1'b1;
          end else begin
            scl_pipe[i] <= scl_pipe[i-1];
            sda_pipe[i] <= sda_pipe[i-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_pipe[STAGES-1];
      sda_q <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cp_pointer.sv
module i2cp_pointer #(
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  input  logic          flip_en,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_nxt;

  always_comb begin
    ptr_nxt = ptr;
    if (load_en) begin
      ptr_nxt = load_val;
    end else if (flip_en) begin
      ptr_nxt = {ptr[AW-1:1], ~ptr[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load_en || flip_en) begin
      ptr <= ptr_nxt;
    end
  end
endmodule

// File: rtl/i2cp_engine.sv
module i2cp_engine
  import i2cp_pkg::*;
#(
  parameter int unsigned AW     = 3,
  parameter int unsigned PIN_W  = 3,
  parameter logic [6-PIN_W:0] DEV_PREFIX = 4'b0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [PIN_W-1:0]   addr_sel,
  input  logic [AW-1:0]      ptr,
  input  logic [BYTE_W-1:0]  rf_rdata,
  output logic               ptr_load,
  output logic [AW-1:0]      ptr_load_val,
  output logic               ptr_flip,
  output logic               sda_oe,
  output logic               rf_we,
  output logic [AW-1:0]      rf_waddr,
  output logic [BYTE_W-1:0]  rf_wdata
);
  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W);

  eng_state_t          state, state_nxt;
  logic [BITCNT_W-1:0] bit_cnt, bit_cnt_nxt;
  logic [BYTE_W-1:0]   shreg, shreg_nxt;
  logic                rw, rw_nxt;
  logic                nack, nack_nxt;
  logic                oe_nxt;
  logic                we_nxt;
  logic [6:0]          own_addr;
  logic                writable;

  assign own_addr     = {DEV_PREFIX, addr_sel};
  assign writable     = (ptr[AW-1:1] != '0);
  assign ptr_load_val = shreg[AW-1:0];

  always_comb begin
    state_nxt   = state;
    bit_cnt_nxt = bit_cnt;
    shreg_nxt   = shreg;
    rw_nxt      = rw;
    nack_nxt    = nack;
    oe_nxt      = sda_oe;
    we_nxt      = 1'b0;
    ptr_load    = 1'b0;
    ptr_flip    = 1'b0;
    if (stop_det) begin
      state_nxt = ST_IDLE;
      oe_nxt    = 1'b0;
    end else if (start_det) begin
      state_nxt   = ST_ADDR;
      bit_cnt_nxt = '0;
      oe_nxt      = 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (scl_rise) begin
            shreg_nxt   = {shreg[BYTE_W-2:0], sda_s};
            bit_cnt_nxt = bit_cnt + 1'b1;
          end
          if (scl_fall && bit_cnt == LAST_BIT) begin
            bit_cnt_nxt = '0;
            if (state == ST_ADDR) begin
              if (shreg[7:1] == own_addr) begin
                oe_nxt    = 1'b1;
                rw_nxt    = shreg[0];
                state_nxt = ST_ADDR_ACK;
              end else begin
                state_nxt = ST_IDLE;
              end
            end else begin
              oe_nxt    = 1'b1;
              state_nxt = (state == ST_CMD) ? ST_CMD_ACK : ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            oe_nxt    = 1'b0;
            state_nxt = rw ? ST_RLOAD : ST_CMD;
          end
        end
        ST_CMD_ACK: begin
          if (scl_fall) begin
            oe_nxt    = 1'b0;
            ptr_load  = 1'b1;
            state_nxt = ST_WDATA;
          end
        end
        ST_WDATA_ACK: begin
          if (scl_fall) begin
            oe_nxt    = 1'b0;
            ptr_flip  = 1'b1;
            we_nxt    = writable;
            state_nxt = ST_WDATA;
          end
        end
        ST_RLOAD: begin
          shreg_nxt   = rf_rdata;
          oe_nxt      = ~rf_rdata[BYTE_W-1];
          bit_cnt_nxt = '0;
          state_nxt   = ST_RDATA;
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bit_cnt_nxt = bit_cnt + 1'b1;
          end
          if (scl_fall) begin
            if (bit_cnt == LAST_BIT) begin
              oe_nxt      = 1'b0;
              bit_cnt_nxt = '0;
              state_nxt   = ST_RACK;
            end else begin
              shreg_nxt = {shreg[BYTE_W-2:0], 1'b1};
              oe_nxt    = ~shreg[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack_nxt = sda_s;
          end
          if (scl_fall) begin
            if (nack) begin
              state_nxt = ST_IDLE;
            end else begin
              ptr_flip  = 1'b1;
              state_nxt = ST_RLOAD;
            end
          end
        end
        default: state_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      rw      <= 1'b0;
      nack    <= 1'b0;
      sda_oe  <= 1'b0;
      rf_we   <= 1'b0;
    end else begin
      state   <= state_nxt;
      bit_cnt <= bit_cnt_nxt;
      shreg   <= shreg_nxt;
      rw      <= rw_nxt;
      nack    <= nack_nxt;
      sda_oe  <= oe_nxt;
      rf_we   <= we_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_waddr <= '0;
      rf_wdata <= '0;
    end else if (we_nxt) begin
      rf_waddr <= ptr;
      rf_wdata <= shreg;
    end
  end
endmodule

// File: rtl/i2c_pair_ctrl.sv
module i2c_pair_ctrl #(
  parameter int unsigned AW          = 3,
  parameter int unsigned PIN_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  input  logic [PIN_W-1:0] addr_sel,
  output logic             rf_we,
  output logic [AW-1:0]    rf_waddr,
  output logic [7:0]       rf_wdata,
  output logic [AW-1:0]    rf_raddr,
  input  logic [7:0]       rf_rdata
);
  logic [1:0]    rst_pipe;
  logic          rst_ns;
  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          ptr_load, ptr_flip;
  logic [AW-1:0] ptr_load_val, ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_ns = rst_pipe[1];

  i2cp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ns), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cp_pointer #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_ns), .load_en(ptr_load), .load_val(ptr_load_val),
    .flip_en(ptr_flip), .ptr(ptr)
  );

  i2cp_engine #(.AW(AW), .PIN_W(PIN_W)) u_eng (
    .clk(clk), .rst_n(rst_ns), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_sel(addr_sel), .ptr(ptr), .rf_rdata(rf_rdata),
    .ptr_load(ptr_load), .ptr_load_val(ptr_load_val), .ptr_flip(ptr_flip),
    .sda_oe(sda_oe), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  assign rf_raddr = ptr;
endmodule

// File: rtl/i2cp_checker.sv
module i2cp_checker #(
  parameter int unsigned AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          stop_det,
  input logic          sda_oe,
  input logic          rf_we,
  input logic [AW-1:0] rf_waddr
);
  // R6: input registers are never written
  p_no_input_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr[AW-1:1] != '0));

  // R5: write strobe lasts one cycle
  p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  // R5: commit happens after the acknowledge clock has fallen
  p_we_clock_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !scl_s);

  // R7: data line is pulled only while the clock is low
  p_oe_rise_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  // R9: a STOP leaves the data line released
  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
endmodule

bind i2c_pair_ctrl i2cp_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_ns), .scl_s(scl_s), .stop_det(stop_det),
  .sda_oe(sda_oe), .rf_we(rf_we), .rf_waddr(rf_waddr)
);

// File: tb/tb_i2c_pair_ctrl.sv
module tb_i2c_pair_ctrl;
  localparam int Q = 10;
  localparam int NVEC = 7;
  // each entry: command, data0, data1, data2
  localparam logic [31:0] VEC [NVEC] = '{
    32'h03_A5_3C_81, 32'h06_0F_F0_55, 32'h04_12_34_56, 32'h02_FF_00_7E,
    32'h00_11_22_33, 32'hF5_C3_96_E1, 32'h07_80_01_AA
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] pins = 3'b010;
  logic       sda_oe, rf_we;
  logic [2:0] rf_waddr, rf_raddr;
  logic [7:0] rf_wdata, rf_rdata;
  logic       sda_line;
  logic [7:0] mem [8];
  logic [7:0] exp_reg [8];
  int         n_chk = 0;
  int         n_bad = 0;
  int         snap_idx = 2;
  logic [7:0] snap_mid;
  bit         done = 0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;
  assign rf_rdata = mem[rf_raddr];

  i2c_pair_ctrl dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .addr_sel(pins), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mem[i] <= 8'(8'h40 + i);
    end else if (rf_we) begin
      mem[rf_waddr] <= rf_wdata;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic qwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(Q); scl = 1'b1; qwait(Q);
    sda_m = 1'b0; qwait(Q); scl = 1'b0; qwait(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(Q); scl = 1'b1; qwait(Q);
    sda_m = 1'b1; qwait(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qwait(Q); scl = 1'b1; qwait(2 * Q); scl = 1'b0;
    end
    sda_m = 1'b1; qwait(Q); scl = 1'b1; qwait(Q);
    ack = ~sda_line; snap_mid = mem[snap_idx];
    qwait(Q); scl = 1'b0; qwait(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qwait(Q); scl = 1'b1; qwait(Q); b[i] = sda_line; qwait(Q); scl = 1'b0;
    end
    sda_m = ~mack; qwait(Q); scl = 1'b1; qwait(2 * Q); scl = 1'b0; qwait(Q);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] addr_byte(input logic [2:0] p, input logic rd);
    return {4'b0100, p, rd};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] rd;
    for (int i = 0; i < 8; i++) exp_reg[i] = 8'(8'h40 + i);
    qwait(5);
    chk("R1 sda_oe in reset", {7'd0, sda_oe}, 8'd0);
    rst_n = 1'b1;
    qwait(10);
    chk("R1 sda_oe after reset", {7'd0, sda_oe}, 8'd0);
    chk("R1 rf_we after reset", {7'd0, rf_we}, 8'd0);

    // table walk: write 3-byte burst, read it back as a 3-byte burst
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] c, d0, d1, d2;
      logic [2:0] p;
      {c, d0, d1, d2} = VEC[v];
      p = c[2:0];
      bus_start();
      send_byte(addr_byte(pins, 1'b0), ack); chk("R2 write address ack", {7'd0, ack}, 8'd1);
      send_byte(c, ack);  chk("R3 command ack", {7'd0, ack}, 8'd1);
      send_byte(d0, ack); chk("R4 data0 ack", {7'd0, ack}, 8'd1);
      send_byte(d1, ack); chk("R4 data1 ack", {7'd0, ack}, 8'd1);
      send_byte(d2, ack); chk("R6 data2 ack", {7'd0, ack}, 8'd1);
      bus_stop();
      if (p[2:1] != 2'b00) begin
        exp_reg[p] = d2;
        exp_reg[p ^ 3'd1] = d1;
      end
      bus_start();
      send_byte(addr_byte(pins, 1'b0), ack);
      send_byte(c, ack);
      bus_start();
      send_byte(addr_byte(pins, 1'b1), ack); chk("R7 read address ack", {7'd0, ack}, 8'd1);
      recv_byte(1'b1, rd); chk("R7 R4 read first", rd, exp_reg[p]);
      recv_byte(1'b1, rd); chk("R7 R4 read second", rd, exp_reg[p ^ 3'd1]);
      recv_byte(1'b0, rd); chk("R7 R6 read third", rd, exp_reg[p]);
      bus_stop();
    end

    // R2: wrong strap pins; later bytes also unacknowledged
    bus_start();
    send_byte(addr_byte(pins ^ 3'b001, 1'b0), ack); chk("R2 mismatch no ack", {7'd0, ack}, 8'd0);
    send_byte(8'h02, ack); chk("R2 no ack after mismatch", {7'd0, ack}, 8'd0);
    bus_stop();

    // R2: other strap setting
    pins = 3'b101; qwait(Q);
    bus_start();
    send_byte(addr_byte(3'b101, 1'b0), ack); chk("R2 new pins ack", {7'd0, ack}, 8'd1);
    bus_stop();

    // R5: commit timing at the acknowledge of a write to register 2
    bus_start();
    send_byte(addr_byte(pins, 1'b0), ack);
    send_byte(8'h02, ack);
    snap_idx = 2;
    send_byte(8'h5A, ack);
    chk("R5 old value during ack", snap_mid, exp_reg[2]);
    chk("R5 new value after ack fall", mem[2], 8'h5A);
    exp_reg[2] = 8'h5A;
    bus_stop();

    // R8: NACK ends read; further clocks read all ones
    bus_start();
    send_byte(addr_byte(pins, 1'b0), ack);
    send_byte(8'h02, ack);
    bus_start();
    send_byte(addr_byte(pins, 1'b1), ack);
    recv_byte(1'b0, rd); chk("R8 byte before nack", rd, 8'h5A);
    recv_byte(1'b0, rd); chk("R8 released after nack", rd, 8'hFF);
    bus_stop();

    // R9: bytes after STOP are ignored
    send_byte(addr_byte(pins, 1'b0), ack); chk("R9 no ack after stop", {7'd0, ack}, 8'd0);
    chk("R9 sda released", {7'd0, sda_oe}, 8'd0);

    // R9: START in mid-byte restarts the address phase
    bus_start();
    for (int i = 0; i < 4; i++) begin
      sda_m = i[0]; qwait(Q); scl = 1'b1; qwait(2 * Q); scl = 1'b0;
    end
    bus_start();
    send_byte(addr_byte(pins, 1'b0), ack); chk("R9 ack after restart", {7'd0, ack}, 8'd1);
    bus_stop();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule